// File: doc/BRIEF.md
# Serial Port FIFO Event and Interrupt Unit

This block sits between a register bus and the shift engine of a serial port. It holds two queues. The transmit queue is filled by bus writes to the data register and drained by the shift engine. The receive queue is filled by the shift engine and drained by bus reads of the data register. The block watches both queues and turns their state into events: a level crossing, empty, full, overrun and underrun.

Each event sets a latched flag that software clears by writing a one to its bit. An interrupt output and a wake output each combine the flags with their own enable masks. Two DMA request lines follow the transmit and receive level conditions while DMA is enabled in that direction. Software programs the levels, the DMA enables and the masks through the register port, and can empty either queue with a clear command.

Register map (word addresses on `regAddr`): 0 data, 1 configuration, 2 fill counts, 3 interrupt flags, 4 interrupt enables, 5 wake flags, 6 wake enables. Other addresses read as zero.

Top module: `fifo_event_unit`

## Requirements
- R1: After reset, both fill counts, all interrupt and wake flags, `irq`, `wake`, `txDmaReq` and `rxDmaReq` are 0. The transmit queue is empty at reset, but that condition does not set its flag.
- R2: A bus write to address 0 pushes one transmit entry. Byte lane i (bits 8i+7..8i) is stored from `regWdata` when `regBe[i]` is 1 and is stored as zero when it is 0. `txPopData` shows the oldest entry, or 0 when the queue is empty. `txPop` removes that entry, so entries leave in the order they were written.
- R3: `rxPush` stores `rxPushData` in the receive queue. A bus read of address 0 with `regRd` high returns the oldest receive entry on `regRdata` in the same cycle and removes it. It returns 0 when the queue is empty.
- R4: Address 2 reads the transmit fill count in bits 7..0 and the receive fill count in bits 15..8.
- R5: The transmit level is in address 1 bits 5..0. While the transmit count is below that level, the transmit level condition holds, and `txDmaReq` equals that condition ANDed with the transmit DMA enable in address 1 bit 16. Interrupt flag bit 0 and wake flag bit 0 are set on the rising edge of the condition.
- R6: The receive level is in address 1 bits 13..8. While the receive count is above that level, the receive level condition holds, and `rxDmaReq` equals that condition ANDed with the receive DMA enable in address 1 bit 17. Interrupt and wake flag bit 2 are set on its rising edge.
- R7: Interrupt and wake flag bit 1 are set when the transmit queue becomes empty. Interrupt and wake flag bit 3 are set when the receive queue becomes full.
- R8: A data write to a full transmit queue sets interrupt flag bit 4 (transmit overrun) and leaves the queue contents and count unchanged. A `txPop` on an empty transmit queue sets bit 5 (transmit underrun).
- R9: An `rxPush` into a full receive queue sets interrupt flag bit 6 (receive overrun) and leaves the queue unchanged. A data read of an empty receive queue sets bit 7 (receive underrun).
- R10: Writing 1 to a bit of address 3 or address 5 clears that flag, and writing 0 leaves it unchanged. A flag event in the same cycle as its clear wins. A flag cleared while its condition still holds is not set again until the condition falls and rises.
- R11: `irq` is the OR of the interrupt flags ANDed with the enables at address 4. `wake` is the OR of the four wake flags ANDed with the enables at address 5's partner, address 6. Wake flags and interrupt flags are cleared independently.
- R12: Writing 1 to address 1 bit 20 (transmit) or bit 21 (receive) empties that queue. It clears that queue's interrupt flags (transmit 0, 1, 4, 5; receive 2, 3, 6, 7) and its wake flags (transmit 0, 1; receive 2, 3). The emptying does not itself raise an event.
- R13: A push and a pop of the same queue in one cycle leave the count unchanged when the queue is neither empty nor full. When the queue is full, the push is rejected as an overrun and the pop is taken. When the queue is empty, the pop is rejected as an underrun and the push is taken.
- R14: Clearing a DMA enable bit drops that direction's request from the next cycle, even while its level condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 3 | Register word address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; a read of address 0 pops the receive queue |
| regBe | input | 4 | Byte enables for data writes |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for the current address |
| txPop | input | 1 | Shift engine takes one transmit entry |
| txPopData | output | 32 | Oldest transmit entry |
| rxPush | input | 1 | Shift engine delivers one receive entry |
| rxPushData | input | 32 | Receive entry being delivered |
| irq | output | 1 | Masked OR of interrupt flags |
| wake | output | 1 | Masked OR of wake flags |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |

## Verification
Two operations can land in the same cycle. One is a write-one-to-clear of a flag together with the event that sets that same flag. The bench provokes this by raising `txPop` on an empty transmit queue in the very cycle it writes 1 to the underrun bit, then reads the flag back and expects it still set. The other is a push and a pop of the same queue in one cycle. The bench drives this at an empty queue, a partly filled queue and a full queue, and judges the result from the read-back count, the popped data and the overrun or underrun flag.

// File: rtl/fifo_event_pkg.sv
package fifo_event_pkg;

  localparam int ADDR_W = 3;
  localparam int FLAG_W = 8;
  localparam int WAKE_W = 4;

  // interrupt flag bit positions (wake flags use the low four)
  localparam int F_TX_THR  = 0;
  localparam int F_TX_EMP  = 1;
  localparam int F_RX_THR  = 2;
  localparam int F_RX_FULL = 3;

  localparam logic [FLAG_W-1:0] TX_FLAG_MASK = 8'h33;
  localparam logic [FLAG_W-1:0] RX_FLAG_MASK = 8'hCC;
  localparam logic [WAKE_W-1:0] TX_WAKE_MASK = 4'h3;
  localparam logic [WAKE_W-1:0] RX_WAKE_MASK = 4'hC;

  // register word addresses
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT   = 3'd2;
  localparam logic [ADDR_W-1:0] A_IFLAG = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd4;
  localparam logic [ADDR_W-1:0] A_WFLAG = 3'd5;
  localparam logic [ADDR_W-1:0] A_WEN   = 3'd6;

  // configuration register fields
  localparam int CFG_TXLVL = 0;
  localparam int CFG_RXLVL = 8;
  localparam int CFG_TXDMA = 16;
  localparam int CFG_RXDMA = 17;
  localparam int CFG_TXCLR = 20;
  localparam int CFG_RXCLR = 21;
  localparam int CNT_TX_LSB = 0;
  localparam int CNT_RX_LSB = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txClr;
    logic rxClr;
  } dp_strobe_t;

endpackage

// File: rtl/fifo_event_fifo.sv
module fifo_event_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [W-1:0]     pushData,
  input  logic             pop,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic [W-1:0]     head,
  output logic             overrun,
  output logic             underrun
);

  logic [W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic full, empty, doPush, doPop;

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign doPush   = push && !full && !clr;
  assign doPop    = pop && !empty && !clr;
  assign overrun  = push && full && !clr;
  assign underrun = pop && empty && !clr;
  assign head     = empty ? '0 : mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

endmodule

// File: rtl/fifo_event_datapath.sv
module fifo_event_datapath
  import fifo_event_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        stb,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              txPop,
  output logic [DATA_W-1:0] txPopData,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  output logic [DATA_W-1:0] rxHead,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic [3:0]        fifoErr   // {rxUnd, rxOvr, txUnd, txOvr}
);

  logic txOvr, txUnd, rxOvr, rxUnd;

  fifo_event_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .push(stb.txPush), .pushData(txWrData),
    .pop(txPop), .clr(stb.txClr),
    .count(txCount), .head(txPopData),
    .overrun(txOvr), .underrun(txUnd)
  );

  fifo_event_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(rxPush), .pushData(rxPushData),
    .pop(stb.rxPop), .clr(stb.rxClr),
    .count(rxCount), .head(rxHead),
    .overrun(rxOvr), .underrun(rxUnd)
  );

  assign fifoErr = {rxUnd, rxOvr, txUnd, txOvr};

endmodule

// File: rtl/fifo_event_ctrl.sv
module fifo_event_ctrl
  import fifo_event_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH = 8,
  parameter int LVL_W = 6,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BE_W = DATA_W / 8,
  localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [BE_W-1:0]   regBe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output dp_strobe_t        stb,
  output logic [DATA_W-1:0] txWrData,
  input  logic [DATA_W-1:0] rxHead,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [3:0]        fifoErr,
  output logic              irq,
  output logic              wake,
  output logic              txDmaReq,
  output logic              rxDmaReq
);

  logic [LVL_W-1:0]  txLevel, rxLevel;
  logic              txDmaEn, rxDmaEn;
  logic [FLAG_W-1:0] irqFlags, irqEn, flagEvt, flagKill, irqW1c;
  logic [WAKE_W-1:0] wakeFlags, wakeEn, wakeW1c, cond, condPrev, rise, prevForce;
  logic              cfgWr;

  // byte-lane selection for data writes
  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign txWrData[8*i +: 8] = regBe[i] ? regWdata[8*i +: 8] : 8'h00;
  end

  assign cfgWr      = regWr && (regAddr == A_CFG);
  assign stb.txPush = regWr && (regAddr == A_DATA);
  assign stb.rxPop  = regRd && (regAddr == A_DATA);
  assign stb.txClr  = cfgWr && regWdata[CFG_TXCLR];
  assign stb.rxClr  = cfgWr && regWdata[CFG_RXCLR];

  // level conditions
  always_comb begin
    cond            = '0;
    cond[F_TX_THR]  = CMP_W'(txCount) < CMP_W'(txLevel);
    cond[F_TX_EMP]  = (txCount == '0);
    cond[F_RX_THR]  = CMP_W'(rxCount) > CMP_W'(rxLevel);
    cond[F_RX_FULL] = (rxCount == CNT_W'(DEPTH));
  end

  assign rise    = cond & ~condPrev;
  assign flagEvt = {fifoErr, rise};

  assign flagKill  = (stb.txClr ? TX_FLAG_MASK : '0) | (stb.rxClr ? RX_FLAG_MASK : '0);
  assign prevForce = (stb.txClr ? TX_WAKE_MASK : '0) | (stb.rxClr ? RX_WAKE_MASK : '0);
  assign irqW1c    = (regWr && regAddr == A_IFLAG) ? regWdata[FLAG_W-1:0] : '0;
  assign wakeW1c   = (regWr && regAddr == A_WFLAG) ? regWdata[WAKE_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condPrev  <= '1;
      irqFlags  <= '0;
      wakeFlags <= '0;
    end else begin
      condPrev  <= cond | prevForce;
      irqFlags  <= ((irqFlags & ~irqW1c) | flagEvt) & ~flagKill;
      wakeFlags <= ((wakeFlags & ~wakeW1c) | rise) & ~flagKill[WAKE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLevel <= '0;
      rxLevel <= '0;
      txDmaEn <= 1'b0;
      rxDmaEn <= 1'b0;
      irqEn   <= '0;
      wakeEn  <= '0;
    end else if (regWr) begin
      case (regAddr)
        A_CFG: begin
          txLevel <= regWdata[CFG_TXLVL +: LVL_W];
          rxLevel <= regWdata[CFG_RXLVL +: LVL_W];
          txDmaEn <= regWdata[CFG_TXDMA];
          rxDmaEn <= regWdata[CFG_RXDMA];
        end
        A_IEN:   irqEn  <= regWdata[FLAG_W-1:0];
        A_WEN:   wakeEn <= regWdata[WAKE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_DATA: regRdata = rxHead;
      A_CFG: begin
        regRdata[CFG_TXLVL +: LVL_W] = txLevel;
        regRdata[CFG_RXLVL +: LVL_W] = rxLevel;
        regRdata[CFG_TXDMA]          = txDmaEn;
        regRdata[CFG_RXDMA]          = rxDmaEn;
      end
      A_CNT: begin
        regRdata[CNT_TX_LSB +: CNT_W] = txCount;
        regRdata[CNT_RX_LSB +: CNT_W] = rxCount;
      end
      A_IFLAG: regRdata[FLAG_W-1:0] = irqFlags;
      A_IEN:   regRdata[FLAG_W-1:0] = irqEn;
      A_WFLAG: regRdata[WAKE_W-1:0] = wakeFlags;
      A_WEN:   regRdata[WAKE_W-1:0] = wakeEn;
      default: regRdata = '0;
    endcase
  end

  assign irq      = |(irqFlags & irqEn);
  assign wake     = |(wakeFlags & wakeEn);
  assign txDmaReq = txDmaEn && cond[F_TX_THR];
  assign rxDmaReq = rxDmaEn && cond[F_RX_THR];

endmodule

// File: rtl/fifo_event_unit.sv
module fifo_event_unit
  import fifo_event_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH = 8,
  parameter int LVL_W = 6,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [BE_W-1:0]   regBe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              txPop,
  output logic [DATA_W-1:0] txPopData,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  output logic              irq,
  output logic              wake,
  output logic              txDmaReq,
  output logic              rxDmaReq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  dp_strobe_t        dpStb;
  logic [DATA_W-1:0] txWrData, rxHead;
  logic [CNT_W-1:0]  txCount, rxCount;
  logic [3:0]        fifoErr;

  fifo_event_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regBe(regBe),
    .regWdata(regWdata), .regRdata(regRdata),
    .stb(dpStb), .txWrData(txWrData), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount), .fifoErr(fifoErr),
    .irq(irq), .wake(wake), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  fifo_event_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(dpStb), .txWrData(txWrData),
    .txPop(txPop), .txPopData(txPopData),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount), .fifoErr(fifoErr)
  );

endmodule

// File: rtl/fifo_event_checker.sv
module fifo_event_checker
  import fifo_event_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input dp_strobe_t       dpStb,
  input logic             txPop,
  input logic             rxPush,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic             rxDmaReq
);

  p_count_bound_r13: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CNT_W'(DEPTH)) && (rxCount <= CNT_W'(DEPTH)));

  p_tx_ovr_keeps_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dpStb.txPush && txCount == CNT_W'(DEPTH) && !txPop && !dpStb.txClr)
      |=> (txCount == CNT_W'(DEPTH)));

  p_tx_und_keeps_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && txCount == '0 && !dpStb.txPush && !dpStb.txClr) |=> (txCount == '0));

  p_rx_ovr_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxCount == CNT_W'(DEPTH) && !dpStb.rxPop && !dpStb.rxClr)
      |=> (rxCount == CNT_W'(DEPTH)));

  p_tx_clear_empties_r12: assert property (@(posedge clk) disable iff (!rstN)
    dpStb.txClr |=> (txCount == '0));

  p_rx_clear_empties_r12: assert property (@(posedge clk) disable iff (!rstN)
    dpStb.rxClr |=> (rxCount == '0));

  p_tx_both_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (dpStb.txPush && txPop && !dpStb.txClr && txCount != '0 && txCount != CNT_W'(DEPTH))
      |=> $stable(txCount));

  p_rx_dma_nonempty_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxDmaReq |-> (rxCount != '0));

endmodule

bind fifo_event_unit fifo_event_checker #(.DEPTH(DEPTH)) u_checker (
  .clk(clk), .rstN(rstN), .dpStb(dpStb), .txPop(txPop), .rxPush(rxPush),
  .txCount(txCount), .rxCount(rxCount), .rxDmaReq(rxDmaReq)
);

// File: tb/fifo_event_unit_bench.sv
module fifo_event_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  localparam logic [2:0] A_DATA = 3'd0, A_CFG = 3'd1, A_CNT = 3'd2, A_IFLAG = 3'd3,
                         A_IEN = 3'd4, A_WFLAG = 3'd5, A_WEN = 3'd6;
  localparam logic [31:0] TXDMA = 32'h1 << 16, RXDMA = 32'h1 << 17,
                          TXCLR = 32'h1 << 20, RXCLR = 32'h1 << 21;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [3:0] regBe = 4'hF;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic txPop = 1'b0;
  logic [31:0] txPopData;
  logic rxPush = 1'b0;
  logic [31:0] rxPushData = '0;
  logic irq, wake, txDmaReq, rxDmaReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_event_unit u_fifo_event_unit (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regBe(regBe), .regWdata(regWdata), .regRdata(regRdata),
    .txPop(txPop), .txPopData(txPopData), .rxPush(rxPush), .rxPushData(rxPushData),
    .irq(irq), .wake(wake), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    regAddr = a; regWdata = d; regBe = be; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regBe = 4'hF;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic rxRead(output logic [31:0] d);
    @(negedge clk);
    regAddr = A_DATA; regRd = 1'b1;
    #1;
    d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic serPop(output logic [31:0] d);
    @(negedge clk);
    txPop = 1'b1;
    #1;
    d = txPopData;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic serPush(input logic [31:0] d);
    @(negedge clk);
    rxPush = 1'b1; rxPushData = d;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  function automatic logic [31:0] laneMask(input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    idle(3);
    rstN = 1'b1;
    idle(3);

    // R1 reset state
    peek(A_CNT, d);   checkEq("R1 counts", d, 0);
    peek(A_IFLAG, d); checkEq("R1 irq flags", d, 0);
    peek(A_WFLAG, d); checkEq("R1 wake flags", d, 0);
    checkEq("R1 irq/wake/dma", {28'b0, irq, wake, txDmaReq, rxDmaReq}, 0);

    // R5 R4 transmit level sweep
    for (int L = 0; L < 10; L++) begin
      regWrite(A_CFG, 32'(L) | TXDMA | TXCLR, 4'hF);
      for (int n = 0; n <= DEPTH; n++) begin
        peek(A_CNT, d);
        checkEq("R4 tx count", {24'b0, d[7:0]}, n);
        checkEq("R5 txDmaReq", 32'(txDmaReq), (n < L) ? 1 : 0);
        if (n < DEPTH) regWrite(A_DATA, 32'(n), 4'hF);
      end
    end
    // R14 disable drops request
    regWrite(A_CFG, 32'd9, 4'hF);
    checkEq("R14 tx dma off", 32'(txDmaReq), 0);
    regWrite(A_CFG, 32'd9 | TXDMA, 4'hF);
    checkEq("R14 tx dma back on", 32'(txDmaReq), 1);

    // R2 byte lanes and ordering, R8 underrun
    regWrite(A_CFG, TXCLR | RXCLR, 4'hF);
    for (int i = 0; i < DEPTH; i++)
      regWrite(A_DATA, 32'h1122_3344 * (i + 1), 4'((i * 5 + 1) & 15));
    for (int i = 0; i < DEPTH; i++) begin
      serPop(d);
      checkEq("R2 tx pop data", d, laneMask(32'h1122_3344 * (i + 1), 4'((i * 5 + 1) & 15)));
    end
    serPop(d);
    checkEq("R2 empty pop data zero", d, 0);
    idle(1);
    peek(A_IFLAG, d);
    checkEq("R8 tx underrun flag", d & 32'h20, 32'h20);
    checkEq("R7 tx empty flag", d & 32'h2, 32'h2);

    // R8 overrun keeps contents
    regWrite(A_CFG, TXCLR, 4'hF);
    for (int i = 0; i < DEPTH; i++) regWrite(A_DATA, 32'hC0 + i, 4'hF);
    regWrite(A_DATA, 32'hDEAD, 4'hF);
    idle(1);
    peek(A_IFLAG, d); checkEq("R8 tx overrun flag", d & 32'h10, 32'h10);
    peek(A_CNT, d);   checkEq("R8 tx count after overrun", {24'b0, d[7:0]}, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      serPop(d);
      checkEq("R8 tx contents kept", d, 32'hC0 + i);
    end

    // R6 receive level sweep
    for (int L = 0; L < 10; L++) begin
      regWrite(A_CFG, (32'(L) << 8) | RXDMA | RXCLR, 4'hF);
      for (int n = 0; n <= DEPTH; n++) begin
        peek(A_CNT, d);
        checkEq("R4 rx count", {24'b0, d[15:8]}, n);
        checkEq("R6 rxDmaReq", 32'(rxDmaReq), (n > L) ? 1 : 0);
        if (n < DEPTH) serPush(32'(n * 3 + L));
      end
    end
    serPush(32'hBAD);
    idle(1);
    peek(A_IFLAG, d);
    checkEq("R9 rx overrun flag", d & 32'h40, 32'h40);
    checkEq("R7 rx full flag", d & 32'h8, 32'h8);
    peek(A_WFLAG, d);
    checkEq("R7 rx full wake flag", d & 32'h8, 32'h8);
    regWrite(A_CFG, RXDMA, 4'hF);
    checkEq("R14 rx dma on", 32'(rxDmaReq), 1);
    regWrite(A_CFG, 32'h0, 4'hF);
    checkEq("R14 rx dma off", 32'(rxDmaReq), 0);
    for (int i = 0; i < DEPTH; i++) begin
      rxRead(d);
      checkEq("R3 rx read data", d, 32'(i * 3 + 9));
    end
    rxRead(d);
    checkEq("R3 empty read zero", d, 0);
    idle(1);
    peek(A_IFLAG, d);
    checkEq("R9 rx underrun flag", d & 32'h80, 32'h80);

    // R10 edge behaviour and W1C
    regWrite(A_CFG, TXCLR | RXCLR, 4'hF);
    regWrite(A_DATA, 32'h1, 4'hF);
    serPop(d);
    idle(1);
    peek(A_IFLAG, d); checkEq("R7 tx empty rise", d, 32'h2);
    regWrite(A_IFLAG, 32'h0, 4'hF);
    peek(A_IFLAG, d); checkEq("R10 write zero keeps", d, 32'h2);
    regWrite(A_IFLAG, 32'h2, 4'hF);
    idle(4);
    peek(A_IFLAG, d); checkEq("R10 no re-set while held", d, 32'h0);
    regWrite(A_DATA, 32'h2, 4'hF);
    serPop(d);
    idle(1);
    peek(A_IFLAG, d); checkEq("R10 set again after fall/rise", d, 32'h2);

    // R10 clear colliding with underrun event
    serPop(d);
    idle(1);
    @(negedge clk);
    regAddr = A_IFLAG; regWdata = 32'h20; regWr = 1'b1; txPop = 1'b1;
    @(negedge clk);
    regWr = 1'b0; txPop = 1'b0;
    peek(A_IFLAG, d); checkEq("R10 event beats clear", d & 32'h20, 32'h20);
    regWrite(A_IFLAG, 32'h20, 4'hF);
    peek(A_IFLAG, d); checkEq("R10 clear alone", d & 32'h20, 32'h0);

    // R11 masks, R5 level flag
    regWrite(A_CFG, TXCLR | RXCLR, 4'hF);
    regWrite(A_IEN, 32'h0, 4'hF);
    regWrite(A_WEN, 32'h0, 4'hF);
    regWrite(A_DATA, 32'h3, 4'hF);
    serPop(d);
    idle(1);
    checkEq("R11 irq masked", 32'(irq), 0);
    regWrite(A_IEN, 32'h2, 4'hF);
    checkEq("R11 irq enabled", 32'(irq), 1);
    regWrite(A_IEN, 32'hFD, 4'hF);
    checkEq("R11 irq other enables", 32'(irq), 0);
    peek(A_WFLAG, d); checkEq("R11 wake flag set", d, 32'h2);
    checkEq("R11 wake masked", 32'(wake), 0);
    regWrite(A_WEN, 32'h2, 4'hF);
    checkEq("R11 wake enabled", 32'(wake), 1);
    regWrite(A_WFLAG, 32'h2, 4'hF);
    checkEq("R11 wake cleared", 32'(wake), 0);
    peek(A_IFLAG, d); checkEq("R11 irq flag independent", d & 32'h2, 32'h2);
    regWrite(A_CFG, 32'd2, 4'hF);
    idle(1);
    peek(A_IFLAG, d); checkEq("R5 tx level flag", d & 32'h1, 32'h1);
    peek(A_WFLAG, d); checkEq("R5 tx level wake flag", d & 32'h1, 32'h1);

    // R12 per-queue clear
    for (int i = 0; i <= DEPTH; i++) regWrite(A_DATA, 32'(i), 4'hF);
    rxRead(d);
    idle(1);
    regWrite(A_CFG, TXCLR, 4'hF);
    idle(3);
    peek(A_CNT, d);   checkEq("R12 tx count zero", {24'b0, d[7:0]}, 0);
    peek(A_IFLAG, d); checkEq("R12 tx flags cleared, rx kept", d, 32'h80);
    peek(A_WFLAG, d); checkEq("R12 tx wake cleared", d & 32'h3, 0);
    for (int i = 0; i < 3; i++) serPush(32'(i));
    regWrite(A_CFG, RXCLR, 4'hF);
    idle(3);
    peek(A_CNT, d);   checkEq("R12 rx count zero", {24'b0, d[15:8]}, 0);
    peek(A_IFLAG, d); checkEq("R12 rx flags cleared", d & 32'hCC, 0);

    // R13 simultaneous push and pop
    regWrite(A_CFG, TXCLR | RXCLR, 4'hF);
    for (int i = 0; i < 3; i++) regWrite(A_DATA, 32'h50 + i, 4'hF);
    @(negedge clk);
    regAddr = A_DATA; regWdata = 32'h99; regWr = 1'b1; txPop = 1'b1;
    #1 d = txPopData;
    checkEq("R13 mid pop data", d, 32'h50);
    @(negedge clk);
    regWr = 1'b0; txPop = 1'b0;
    peek(A_CNT, d); checkEq("R13 mid count held", {24'b0, d[7:0]}, 3);
    for (int i = 3; i < DEPTH; i++) regWrite(A_DATA, 32'h50 + i, 4'hF);
    @(negedge clk);
    regAddr = A_DATA; regWdata = 32'h77; regWr = 1'b1; txPop = 1'b1;
    @(negedge clk);
    regWr = 1'b0; txPop = 1'b0;
    peek(A_CNT, d);   checkEq("R13 full push rejected", {24'b0, d[7:0]}, DEPTH - 1);
    peek(A_IFLAG, d); checkEq("R13 full overrun", d & 32'h10, 32'h10);
    regWrite(A_CFG, TXCLR, 4'hF);
    @(negedge clk);
    regAddr = A_DATA; regWdata = 32'h66; regWr = 1'b1; txPop = 1'b1;
    #1 d = txPopData;
    checkEq("R13 empty pop data zero", d, 0);
    @(negedge clk);
    regWr = 1'b0; txPop = 1'b0;
    peek(A_CNT, d);   checkEq("R13 empty push taken", {24'b0, d[7:0]}, 1);
    peek(A_IFLAG, d); checkEq("R13 empty underrun", d & 32'h20, 32'h20);
    serPop(d);
    checkEq("R13 pushed entry kept", d, 32'h66);
    serPush(32'hA1);
    serPush(32'hA2);
    @(negedge clk);
    regAddr = A_DATA; regRd = 1'b1; rxPush = 1'b1; rxPushData = 32'hA3;
    #1 d = regRdata;
    checkEq("R13 rx read during push", d, 32'hA1);
    @(negedge clk);
    regRd = 1'b0; rxPush = 1'b0;
    peek(A_CNT, d); checkEq("R13 rx count held", {24'b0, d[15:8]}, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule